// File: doc/BRIEF.md
# Secure Peripheral Access Gate

The gate sits between one APB-style requester and a set of downstream peripheral ports (16 by default). Each request carries a port index, a security attribute and a privilege attribute. The gate checks these attributes against two configuration bits for the target port. One bit opens the port to non-secure traffic and the other opens it to user traffic. An access that passes is routed to that port's select line, and the peripheral's ready, read data and error flag come straight back.

An access that fails never reaches a peripheral. It completes at once with ready high, and one input selects how it ends: with an error response, or as a read-as-zero / write-ignored transfer with an OK response. Every blocked transfer sets a sticky status flag. The interrupt output is that flag gated by an enable input. A clear input wipes the flag, and while the clear input is held high, new blocked transfers cannot set the flag again.

All configuration arrives on input pins, so the only storage is the status flag. A compile-time mask can exempt chosen ports from the security check. The privilege check still applies to those ports.

Top module: `periph_guard`

## Requirements
- R1: For a port whose mask bit is clear, a secure access (`req_secure`=1) is allowed only when that port's `cfg_ns_open` bit is 0, and a non-secure access is allowed only when the bit is 1.
- R2: A user access (`req_priv`=0) is blocked whenever the port's `cfg_user_open` bit is 0, whatever the security check decides.
- R3: A port whose bit in the `NS_BYPASS` parameter is set skips the security check but still applies the privilege check (default mask 16'h8000, so port 15 is exempt).
- R4: An allowed access asserts only the target bit of `dn_sel`, and it asserts that bit in both the setup and access phases. `dn_enable`, `dn_write`, `dn_addr`, `dn_wdata` and `dn_strb` equal the upstream values. `up_ready`, `up_rdata` and `up_slverr` are the target port's signals, in the same cycle.
- R5: A blocked access asserts no `dn_sel` bit and drives `up_ready`=1 in its access cycle, whatever the downstream ready lines are doing.
- R6: A blocked access returns `up_rdata`=0. It drives `up_slverr` equal to `cfg_err_resp`, so 1 gives an error and 0 gives an OK response with write data dropped.
- R7: The access phase of a blocked transfer (`up_sel` and `up_enable` both high) sets the status flag at that clock edge. `irq` equals the flag ANDed with `irq_en`, and `irq_en` acts on `irq` without a clock.
- R8: With `irq_clr` high at a clock edge, the flag is 0 after that edge, even if a blocked access phase falls in the same cycle. A blocked transfer while `irq_clr` is held high leaves the flag at 0.
- R9: A synchronous reset clears the flag. While `rst` is high, all per-port configuration bits and `cfg_err_resp` are treated as 0, so only secure privileged accesses pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_sel | input | 1 | Upstream transfer select |
| up_enable | input | 1 | Upstream access phase |
| up_write | input | 1 | Upstream write (1) or read (0) |
| up_port | input | SEL_W | Target port index |
| up_secure | input | 1 | Security attribute, 1 = secure |
| up_priv | input | 1 | Privilege attribute, 1 = privileged |
| up_addr | input | AW | Upstream address |
| up_wdata | input | DW | Upstream write data |
| up_strb | input | DW/8 | Upstream write strobes |
| up_ready | output | 1 | Transfer complete |
| up_rdata | output | DW | Read data |
| up_slverr | output | 1 | Error response |
| dn_sel | output | N_PORTS | Per-port downstream select |
| dn_enable | output | 1 | Downstream access phase |
| dn_write | output | 1 | Downstream write |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_strb | output | DW/8 | Downstream write strobes |
| dn_rdata | input | N_PORTS*DW | Read data per port, port i at bits i*DW |
| dn_ready | input | N_PORTS | Ready per port |
| dn_slverr | input | N_PORTS | Error per port |
| cfg_ns_open | input | N_PORTS | Per-port non-secure open bit |
| cfg_user_open | input | N_PORTS | Per-port user open bit |
| cfg_err_resp | input | 1 | Blocked transfers end with error (1) or zero/OK (0) |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear and hold-off of the status flag |
| irq | output | 1 | Blocked-access interrupt |

## Verification
The routing and response results (`dn_sel`, pass-through buses, `up_ready`, `up_rdata`, `up_slverr`) are combinational and due in the same cycle. The bench therefore samples them one nanosecond after the falling edge that drives the stimulus, with no clock edge between. The flag is due after exactly one rising edge, namely the edge that ends the access phase or that sees `irq_clr` high. The bench checks `irq` after the following falling edge. `irq_en` acts on `irq` at once, so that check also takes place between edges.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;
  // How the upstream side of a transfer is completed.
  typedef enum logic [1:0] {
    RSP_PASS = 2'd0,  // downstream port answers
    RSP_ZERO = 2'd1,  // blocked, OK with zero data
    RSP_ERR  = 2'd2   // blocked, error
  } rsp_kind_e;

  localparam logic [15:0] DEFAULT_BYPASS = 16'h8000;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pg_rule.sv
module pg_rule #(
  parameter int unsigned N_PORTS = 16,
  parameter logic [N_PORTS-1:0] NS_BYPASS = '0
) (
  input  logic [N_PORTS-1:0] ns_open,
  input  logic [N_PORTS-1:0] user_open,
  input  logic               secure,
  input  logic               priv,
  output logic [N_PORTS-1:0] allow
);
  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic sec_ok;
    if (NS_BYPASS[i]) begin : g_bypass
      assign sec_ok = 1'b1;
    end else begin : g_check
      // secure traffic needs the open bit at 0, non-secure needs it at 1
      assign sec_ok = secure ^ ns_open[i];
    end
    assign allow[i] = sec_ok & (priv | user_open[i]);
  end
endmodule

// File: rtl/pg_route.sv
module pg_route
  import periph_guard_pkg::*;
#(
  parameter int unsigned N_PORTS = 16,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DW      = 32
) (
  input  logic                  sel,
  input  logic [SEL_W-1:0]      port,
  input  logic [N_PORTS-1:0]    allow,
  input  logic                  err_resp,
  input  logic [N_PORTS*DW-1:0] rdata_in,
  input  logic [N_PORTS-1:0]    ready_in,
  input  logic [N_PORTS-1:0]    slverr_in,
  output logic [N_PORTS-1:0]    port_sel,
  output logic                  blocked,
  output logic                  ready,
  output logic [DW-1:0]         rdata,
  output logic                  slverr
);
  localparam int unsigned SPAN = 1 << SEL_W;

  logic [SPAN-1:0]    allow_x;
  logic [SPAN-1:0]    ready_x;
  logic [SPAN-1:0]    slverr_x;
  logic [DW-1:0]      rdata_x [SPAN];
  logic               hit;
  rsp_kind_e          kind;

  // Widen to the full index range; unused indices are never allowed.
  for (genvar i = 0; i < SPAN; i++) begin : g_pad
    if (i < N_PORTS) begin : g_real
      assign allow_x[i]  = allow[i];
      assign ready_x[i]  = ready_in[i];
      assign slverr_x[i] = slverr_in[i];
      assign rdata_x[i]  = rdata_in[i*DW +: DW];
    end else begin : g_void
      assign allow_x[i]  = 1'b0;
      assign ready_x[i]  = 1'b0;
      assign slverr_x[i] = 1'b0;
      assign rdata_x[i]  = '0;
    end
  end

  assign hit     = allow_x[port];
  assign blocked = sel & ~hit;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_sel
    assign port_sel[i] = sel & hit & (port == SEL_W'(i));
  end

  always_comb begin
    if (hit)           kind = RSP_PASS;
    else if (err_resp) kind = RSP_ERR;
    else               kind = RSP_ZERO;
  end

  always_comb begin
    unique case (kind)
      RSP_PASS: begin
        ready  = ready_x[port];
        rdata  = rdata_x[port];
        slverr = slverr_x[port];
      end
      RSP_ERR: begin
        ready  = 1'b1;
        rdata  = '0;
        slverr = 1'b1;
      end
      default: begin
        ready  = 1'b1;
        rdata  = '0;
        slverr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pg_irq.sv
module pg_irq (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic clr,
  input  logic en,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (clr)      flag_q <= 1'b0;   // clear dominates and holds off
    else if (event_in) flag_q <= 1'b1;
  end

  assign irq = flag_q & en;
endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import periph_guard_pkg::*;
#(
  parameter int unsigned N_PORTS = 16,
  parameter int unsigned SEL_W   = sel_width(N_PORTS),
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter logic [N_PORTS-1:0] NS_BYPASS = N_PORTS'(DEFAULT_BYPASS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  up_sel,
  input  logic                  up_enable,
  input  logic                  up_write,
  input  logic [SEL_W-1:0]      up_port,
  input  logic                  up_secure,
  input  logic                  up_priv,
  input  logic [AW-1:0]         up_addr,
  input  logic [DW-1:0]         up_wdata,
  input  logic [DW/8-1:0]       up_strb,
  output logic                  up_ready,
  output logic [DW-1:0]         up_rdata,
  output logic                  up_slverr,
  output logic [N_PORTS-1:0]    dn_sel,
  output logic                  dn_enable,
  output logic                  dn_write,
  output logic [AW-1:0]         dn_addr,
  output logic [DW-1:0]         dn_wdata,
  output logic [DW/8-1:0]       dn_strb,
  input  logic [N_PORTS*DW-1:0] dn_rdata,
  input  logic [N_PORTS-1:0]    dn_ready,
  input  logic [N_PORTS-1:0]    dn_slverr,
  input  logic [N_PORTS-1:0]    cfg_ns_open,
  input  logic [N_PORTS-1:0]    cfg_user_open,
  input  logic                  cfg_err_resp,
  input  logic                  irq_en,
  input  logic                  irq_clr,
  output logic                  irq
);
  logic [N_PORTS-1:0] ns_eff;
  logic [N_PORTS-1:0] user_eff;
  logic               err_eff;
  logic [N_PORTS-1:0] allow;
  logic               blocked;

  // Configuration reads as all-zero while reset is held.
  assign ns_eff   = rst ? '0 : cfg_ns_open;
  assign user_eff = rst ? '0 : cfg_user_open;
  assign err_eff  = rst ? 1'b0 : cfg_err_resp;

  pg_rule #(.N_PORTS(N_PORTS), .NS_BYPASS(NS_BYPASS)) u_rule (
    .ns_open   (ns_eff),
    .user_open (user_eff),
    .secure    (up_secure),
    .priv      (up_priv),
    .allow     (allow)
  );

  pg_route #(.N_PORTS(N_PORTS), .SEL_W(SEL_W), .DW(DW)) u_route (
    .sel       (up_sel),
    .port      (up_port),
    .allow     (allow),
    .err_resp  (err_eff),
    .rdata_in  (dn_rdata),
    .ready_in  (dn_ready),
    .slverr_in (dn_slverr),
    .port_sel  (dn_sel),
    .blocked   (blocked),
    .ready     (up_ready),
    .rdata     (up_rdata),
    .slverr    (up_slverr)
  );

  pg_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .event_in (blocked & up_enable),
    .clr      (irq_clr),
    .en       (irq_en),
    .irq      (irq)
  );

  assign dn_enable = up_enable;
  assign dn_write  = up_write;
  assign dn_addr   = up_addr;
  assign dn_wdata  = up_wdata;
  assign dn_strb   = up_strb;
endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
  parameter int unsigned N_PORTS = 16,
  parameter int unsigned SEL_W   = 4,
  parameter logic [N_PORTS-1:0] NS_BYPASS = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               up_sel,
  input logic               up_enable,
  input logic [SEL_W-1:0]   up_port,
  input logic               up_secure,
  input logic               up_priv,
  input logic               up_ready,
  input logic               up_slverr,
  input logic [N_PORTS-1:0] dn_sel,
  input logic [N_PORTS-1:0] cfg_ns_open,
  input logic [N_PORTS-1:0] cfg_user_open,
  input logic               cfg_err_resp,
  input logic               irq_en,
  input logic               irq_clr,
  input logic               irq
);
  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_sel));

  // R1
  sec_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (up_sel && !NS_BYPASS[up_port] && (up_secure == cfg_ns_open[up_port]))
      |-> (dn_sel == '0));

  // R2
  user_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (up_sel && !up_priv && !cfg_user_open[up_port]) |-> (dn_sel == '0));

  // R5
  block_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (up_sel && up_enable && dn_sel == '0) |-> up_ready);

  // R6
  block_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (up_sel && dn_sel == '0) |-> (up_slverr == cfg_err_resp));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (up_sel && up_enable && dn_sel == '0 && !irq_clr)
      |=> (irq || !irq_en));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq);
endmodule

bind periph_guard periph_guard_chk #(
  .N_PORTS(N_PORTS), .SEL_W(SEL_W), .NS_BYPASS(NS_BYPASS)
) u_chk (.*);

// File: tb/tb_periph_guard.sv
`timescale 1ns/100ps
module tb_periph_guard;
  localparam int N = 16;
  localparam int DW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_sel = 0, up_enable = 0, up_write = 0, up_secure = 0, up_priv = 0;
  logic [3:0] up_port = '0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [3:0] up_strb = '0;
  logic up_ready, up_slverr, dn_enable, dn_write, irq;
  logic [DW-1:0] up_rdata, dn_wdata;
  logic [AW-1:0] dn_addr;
  logic [3:0] dn_strb;
  logic [N-1:0] dn_sel;
  logic [N*DW-1:0] dn_rdata;
  logic [N-1:0] dn_ready = '1, dn_slverr = '0;
  logic [N-1:0] cfg_ns_open = '0, cfg_user_open = '0;
  logic cfg_err_resp = 0, irq_en = 0, irq_clr = 0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_mem
    assign dn_rdata[i*DW +: DW] = 32'hD000_0000 | i;
  end

  periph_guard dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {allow, err, user_open, ns_open, write, priv, secure, port[3:0]}
  function automatic logic [10:0] mkv(input int p, input bit s, input bit pr, input bit w,
                                      input bit ns, input bit ap, input bit er, input bit al);
    return {al, er, ap, ns, w, pr, s, 4'(p)};
  endfunction

  localparam logic [10:0] VEC [12] = '{
    mkv(0, 1, 1, 0, 0, 0, 0, 1),
    mkv(0, 0, 1, 0, 0, 0, 0, 0),
    mkv(3, 0, 1, 1, 1, 0, 1, 1),
    mkv(3, 1, 1, 0, 1, 0, 1, 0),
    mkv(5, 1, 0, 0, 0, 0, 1, 0),
    mkv(5, 1, 0, 0, 0, 1, 1, 1),
    mkv(7, 0, 0, 1, 1, 1, 0, 1),
    mkv(7, 0, 0, 1, 1, 0, 0, 0),
    mkv(15, 0, 1, 0, 0, 0, 0, 1),
    mkv(15, 1, 1, 0, 1, 0, 0, 1),
    mkv(15, 1, 0, 0, 1, 0, 1, 0),
    mkv(9, 1, 1, 1, 0, 1, 1, 1)
  };

  task automatic setup(input int p, input bit s, input bit pr, input bit w);
    @(negedge clk);
    up_sel = 1; up_enable = 0; up_write = w; up_port = 4'(p);
    up_secure = s; up_priv = pr;
    up_addr = 32'h100 + 32'(p) * 4; up_wdata = 32'hC0DE_0000 | p; up_strb = 4'hF;
    @(negedge clk);
    up_enable = 1;
    #1;
  endtask

  task automatic finish_xfer();
    @(posedge clk);
    @(negedge clk);
    up_sel = 0; up_enable = 0;
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state and config forced to zero during reset
    cfg_ns_open = '1; cfg_user_open = '1; irq_en = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(irq == 0, "R9 irq in reset", 64'(irq), 0);
    setup(2, 0, 1, 0);
    chk(dn_sel == 0, "R9 nonsecure blocked in reset", 64'(dn_sel), 0);
    finish_xfer();
    setup(2, 1, 1, 0);
    chk(dn_sel == 16'h0004, "R9 secure priv allowed in reset", 64'(dn_sel), 64'h4);
    finish_xfer();
    setup(4, 1, 0, 0);
    chk(dn_sel == 0, "R9 user blocked in reset", 64'(dn_sel), 0);
    finish_xfer();
    chk(irq == 0, "R9 flag held clear in reset", 64'(irq), 0);
    @(negedge clk); rst = 0;
    @(negedge clk);

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      automatic logic [10:0] v = VEC[k];
      automatic int p = int'(v[3:0]);
      automatic bit al = v[10];
      automatic bit er = v[9];
      automatic logic [N-1:0] exp_sel = al ? (N'(1) << p) : '0;
      automatic logic [DW-1:0] exp_rd = al ? (32'hD000_0000 | p) : 32'h0;
      cfg_ns_open = '0; cfg_user_open = '0;
      cfg_ns_open[p] = v[7]; cfg_user_open[p] = v[8]; cfg_err_resp = er;
      pulse_clr();
      setup(p, v[4], v[5], v[6]);
      chk(dn_sel == exp_sel, $sformatf("R1/R2/R3 vec%0d dn_sel", k), 64'(dn_sel), 64'(exp_sel));
      chk(up_ready == 1'b1, $sformatf("R5 vec%0d ready", k), 64'(up_ready), 1);
      chk(up_slverr == (!al && er), $sformatf("R6 vec%0d slverr", k), 64'(up_slverr), 64'(!al && er));
      if (!v[6])
        chk(up_rdata == exp_rd, $sformatf("R6 vec%0d rdata", k), 64'(up_rdata), 64'(exp_rd));
      if (al)
        chk(dn_addr == up_addr && dn_wdata == up_wdata && dn_enable && dn_write == v[6],
            $sformatf("R4 vec%0d pass-through", k), 64'(dn_addr), 64'(up_addr));
      finish_xfer();
      chk(irq == !al, $sformatf("R7 vec%0d irq", k), 64'(irq), 64'(!al));
    end

    // R4: downstream ready/error returned for an allowed access
    cfg_ns_open = '0; cfg_user_open = '0; cfg_err_resp = 0;
    pulse_clr();
    dn_ready[6] = 0; dn_slverr[6] = 1;
    setup(6, 1, 1, 0);
    chk(up_ready == 0 && up_slverr == 1, "R4 waits on port ready, returns port error",
        64'({up_ready, up_slverr}), 64'h1);
    chk(dn_sel == 16'h0040, "R4 setup/access select", 64'(dn_sel), 64'h40);
    finish_xfer();
    dn_slverr[6] = 0;

    // R5: blocked completes even with every downstream ready low
    dn_ready = '0;
    setup(6, 0, 1, 1);
    chk(up_ready == 1 && dn_sel == 0, "R5 blocked ignores downstream ready",
        64'({up_ready, dn_sel}), 64'h1_0000);
    finish_xfer();
    dn_ready = '1;

    // R7: enable gates output, acts without a clock
    irq_en = 0;
    #1;
    chk(irq == 0, "R7 irq masked by enable", 64'(irq), 0);
    irq_en = 1;
    #1;
    chk(irq == 1, "R7 enable shows pending flag", 64'(irq), 1);

    // R8: clear held high through a blocked transfer leaves flag 0
    @(negedge clk); irq_clr = 1;
    setup(6, 0, 1, 0);
    finish_xfer();
    irq_clr = 0;
    @(negedge clk); #1;
    chk(irq == 0, "R8 held clear suppresses new flag", 64'(irq), 0);

    // R8: clear in the same cycle as the blocked access phase
    @(negedge clk);
    up_sel = 1; up_port = 4'd6; up_secure = 0; up_priv = 1; up_write = 0;
    @(negedge clk);
    up_enable = 1; irq_clr = 1;
    @(negedge clk);
    up_sel = 0; up_enable = 0; irq_clr = 0;
    #1;
    chk(irq == 0, "R8 clear wins over same-cycle block", 64'(irq), 0);

    // R8/R7: an ordinary blocked access afterward sets it again
    setup(6, 0, 1, 0);
    finish_xfer();
    chk(irq == 1, "R7 flag sets after clear released", 64'(irq), 1);

    // R9: synchronous reset clears the flag
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(irq == 0, "R9 reset clears flag", 64'(irq), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule